// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a virtual address into a physical storage address when the fast translation lookup has missed. It reads one word from a segment table to find a page table, then one halfword from that page table to find the physical block, and joins the block number with the byte offset of the virtual address. When an entry is marked unavailable, when the page index is beyond the length of the page table, or when reserved bits of a page entry are set, it stops and reports a program interruption code. It also keeps the failing virtual address.

A caller pulses `start` with a virtual address, a mode select and the table-origin register value. The walker is busy until it pulses `done`, and its results stay unchanged until the next walk ends. Table reads go out on a request/response port with a valid/ready request handshake and a response that may arrive any number of cycles later. All bit positions below are vector indexes, with the highest index as the most significant bit. Multi-byte entries are stored with the most significant byte at the lowest address.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `busy`, `done`, `pa`, `exc_code`, `tea` and `mem_req_valid` are all zero.
- R2: In 24-bit mode the segment index is `va[23:20]`. Bits `va[31:24]` have no effect. The segment entry is read as a word (`mem_req_half`=0) at `{str[23:6],6'b0} + 4*index`, so `str[5:0]` are ignored.
- R3: If bit 0 of the segment entry is 1, the walk ends with code 16 and the page table is not read.
- R4: The page index is `va[19:12]`. If it is greater than segment-entry bits [31:24], the walk ends with code 17 and the page table is not read. An index equal to that value is allowed, so a value of 0 allows one entry.
- R5: The page entry is read as a halfword (`mem_req_half`=1) at `{seg[23:1],1'b0} + 2*page_index`, and it returns in `mem_rsp_data[15:0]`.
- R6: If page-entry bit 3 is 1, the walk ends with code 17. This holds even when bits [2:0] are also nonzero.
- R7: If page-entry bit 3 is 0 and bits [2:0] are not 000, the walk ends with code 6.
- R8: A successful walk gives `exc_code`=0 and `pa` = `{pte[15:4], va[11:0]}`. A walk that ends in an exception sets `pa` to zero.
- R9: Every exception loads `tea` with the virtual address of that walk. A successful walk leaves `tea` unchanged.
- R10: In 32-bit mode the segment index is `va[31:20]`. If that index is greater than `str[31:24]*16+15`, the walk ends with code 16 and no memory read is made.
- R11: `busy` rises in the cycle after an accepted `start` and falls in the same cycle as the one-cycle `done` pulse. A `start` while busy is ignored. `pa`, `exc_code` and `tea` change only in a `done` cycle. A pending request keeps its address and size until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | 32 | Virtual address |
| mode32 | input | 1 | 1 selects 32-bit address mode |
| str | input | 32 | Segment table register: length [31:24], origin [23:0] |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| pa | output | 24 | Physical address |
| exc_code | output | 8 | 0, 6, 16 or 17 |
| tea | output | 32 | Virtual address of the last failing walk |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 24 | Byte address of the table entry |
| mem_req_half | output | 1 | 1 = halfword read, 0 = word read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data (a halfword is in bits [15:0]) |

## Verification
The hardest cases to reach are the ones that must end without a read: a page index just past the page-table length, and a 32-bit segment index past the register's group count. Reaching them only from the ports means building table contents that select exactly that index. The bench places the tables in its own byte-addressed memory and aims virtual addresses at the boundary entries on both sides. Each accepted request is compared with a queue of addresses expected by the reference walk, and the read count is compared when the walk completes. The tests also vary response latency and request stalls, and they send a second `start` while the walker is busy.

// File: rtl/xw_pkg.sv
package xw_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SEG_REQ,
      S_SEG_WAIT,
      S_PG_REQ,
      S_PG_WAIT
   } walk_st_t;

   localparam logic [7:0] XC_NONE = 8'd0;
   localparam logic [7:0] XC_SPEC = 8'd6;
   localparam logic [7:0] XC_SEG  = 8'd16;
   localparam logic [7:0] XC_PAGE = 8'd17;

endpackage

// File: rtl/xw_addr_gen.sv
// Entry address arithmetic and the segment bound check for the wide mode.
module xw_addr_gen #(
   parameter int VPN_W     = 20,
   parameter int ADDR_W    = 24,
   parameter int LEN_W     = 8,
   parameter int GRP_LG    = 4,
   parameter int PAGE_IX_W = 8,
   parameter int SEG_IX_N  = 4,
   parameter int ALIGN_LG  = 6,
   parameter bit EXT_EN    = 1'b1
) (
   input  logic [VPN_W-1:0]        vpn,
   input  logic [LEN_W+ADDR_W-1:0] str,
   input  logic                    mode32,
   input  logic [ADDR_W-1:0]       pto,
   output logic [ADDR_W-1:0]       seg_addr,
   output logic [ADDR_W-1:0]       pg_addr,
   output logic [PAGE_IX_W-1:0]    page_ix,
   output logic                    seg_oob
);
   localparam int SEG_IX_X = LEN_W + GRP_LG;
   localparam int STR_W    = LEN_W + ADDR_W;

   logic [ADDR_W-1:0]   sto;
   logic [SEG_IX_X-1:0] seg_ix;
   logic                unused_align;

   assign sto          = {str[ADDR_W-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
   assign unused_align = ^str[ALIGN_LG-1:0];
   assign page_ix      = vpn[PAGE_IX_W-1:0];

   generate
      if (EXT_EN) begin : g_ext
         logic [SEG_IX_X-1:0] seg_lim;
         assign seg_lim = {str[STR_W-1 -: LEN_W], {GRP_LG{1'b1}}};
         always_comb begin
            if (mode32) seg_ix = vpn[PAGE_IX_W +: SEG_IX_X];
            else        seg_ix = SEG_IX_X'(vpn[PAGE_IX_W +: SEG_IX_N]);
            seg_oob = mode32 && (seg_ix > seg_lim);
         end
      end else begin : g_base
         logic unused_ext;
         assign unused_ext = mode32 ^ (^str[STR_W-1:ADDR_W]) ^ (^vpn[VPN_W-1:PAGE_IX_W+SEG_IX_N]);
         assign seg_ix     = SEG_IX_X'(vpn[PAGE_IX_W +: SEG_IX_N]);
         assign seg_oob    = 1'b0;
      end
   endgenerate

   assign seg_addr = sto + ADDR_W'({seg_ix, 2'b00});
   assign pg_addr  = pto + ADDR_W'({page_ix, 1'b0});

endmodule

// File: rtl/xw_entry_dec.sv
// Field decode of a segment word and a page halfword taken from the response bus.
module xw_entry_dec #(
   parameter int ADDR_W    = 24,
   parameter int LEN_W     = 8,
   parameter int PAGE_IX_W = 8,
   parameter int BLOCK_W   = 12,
   parameter int RSV_W     = 3
) (
   input  logic [LEN_W+ADDR_W-1:0]      seg_word,
   input  logic [BLOCK_W+RSV_W:0]       pg_half,
   input  logic [PAGE_IX_W-1:0]         page_ix,
   output logic                         seg_inv,
   output logic                         len_over,
   output logic [ADDR_W-1:0]            pto,
   output logic                         pg_inv,
   output logic                         pg_rsv,
   output logic [BLOCK_W-1:0]           block
);
   localparam int SEG_W = LEN_W + ADDR_W;
   localparam int PTE_W = BLOCK_W + RSV_W + 1;

   assign seg_inv  = seg_word[0];
   assign pto      = {seg_word[ADDR_W-1:1], 1'b0};
   assign len_over = 32'(page_ix) > 32'(seg_word[SEG_W-1 -: LEN_W]);
   assign block    = pg_half[PTE_W-1 -: BLOCK_W];
   assign pg_inv   = pg_half[RSV_W];
   assign pg_rsv   = |pg_half[RSV_W-1:0];

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int ADDR_W    = 24,
   parameter int OFF_W     = 12,
   parameter int PAGE_IX_W = 8,
   parameter int SEG_IX_N  = 4,
   parameter int LEN_W     = 8,
   parameter int GRP_LG    = 4,
   parameter int ALIGN_LG  = 6,
   parameter int RSV_W     = 3,
   parameter bit EXT_EN    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [VA_W-1:0]         va,
   input  logic                    mode32,
   input  logic [LEN_W+ADDR_W-1:0] str,
   output logic                    busy,
   output logic                    done,
   output logic [ADDR_W-1:0]       pa,
   output logic [7:0]              exc_code,
   output logic [VA_W-1:0]         tea,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [ADDR_W-1:0]       mem_req_addr,
   output logic                    mem_req_half,
   input  logic                    mem_rsp_valid,
   input  logic [LEN_W+ADDR_W-1:0] mem_rsp_data
);
   localparam int STR_W   = LEN_W + ADDR_W;
   localparam int BLOCK_W = ADDR_W - OFF_W;
   localparam int PTE_W   = BLOCK_W + RSV_W + 1;
   localparam int VPN_W   = VA_W - OFF_W;

   // elaboration-time parameter checks
   if (VA_W < OFF_W + PAGE_IX_W + LEN_W + GRP_LG) begin : g_bad_va
      $error("xlat_walker: VA_W too narrow for the wide segment index");
   end
   if (OFF_W + PAGE_IX_W + SEG_IX_N != ADDR_W) begin : g_bad_map
      $error("xlat_walker: narrow-mode fields must span ADDR_W bits");
   end
   if (PTE_W > STR_W) begin : g_bad_pte
      $error("xlat_walker: page entry wider than the data bus");
   end
   if (ALIGN_LG < 2 || ALIGN_LG >= ADDR_W) begin : g_bad_align
      $error("xlat_walker: ALIGN_LG out of range");
   end

   walk_st_t              st, nxt;
   logic [VA_W-1:0]       va_q;
   logic [STR_W-1:0]      str_q;
   logic                  mode_q, mode_in;
   logic [ADDR_W-1:0]     pto_q, pto_w, seg_addr, pg_addr;
   logic [PAGE_IX_W-1:0]  page_ix;
   logic                  seg_oob, seg_inv, len_over, pg_inv, pg_rsv;
   logic [BLOCK_W-1:0]    block;
   logic                  fin;
   logic [7:0]            fcode;

   generate
      if (EXT_EN) begin : g_mode
         assign mode_in = mode32;
      end else begin : g_nomode
         logic unused_mode;
         assign unused_mode = mode32;
         assign mode_in     = 1'b0;
      end
   endgenerate

   xw_addr_gen #(
      .VPN_W(VPN_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .GRP_LG(GRP_LG),
      .PAGE_IX_W(PAGE_IX_W), .SEG_IX_N(SEG_IX_N), .ALIGN_LG(ALIGN_LG), .EXT_EN(EXT_EN)
   ) u_agen (
      .vpn(va_q[VA_W-1:OFF_W]), .str(str_q), .mode32(mode_q), .pto(pto_q),
      .seg_addr(seg_addr), .pg_addr(pg_addr), .page_ix(page_ix), .seg_oob(seg_oob)
   );

   xw_entry_dec #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_IX_W(PAGE_IX_W),
      .BLOCK_W(BLOCK_W), .RSV_W(RSV_W)
   ) u_dec (
      .seg_word(mem_rsp_data), .pg_half(mem_rsp_data[PTE_W-1:0]), .page_ix(page_ix),
      .seg_inv(seg_inv), .len_over(len_over), .pto(pto_w),
      .pg_inv(pg_inv), .pg_rsv(pg_rsv), .block(block)
   );

   assign mem_req_valid = (st == S_SEG_REQ && !seg_oob) || (st == S_PG_REQ);
   assign mem_req_half  = (st == S_PG_REQ);
   assign mem_req_addr  = (st == S_PG_REQ) ? pg_addr : seg_addr;

   always_comb begin
      fin   = 1'b0;
      fcode = XC_NONE;
      nxt   = st;
      case (st)
         S_IDLE:     if (start) nxt = S_SEG_REQ;
         S_SEG_REQ: begin
            if (seg_oob) begin
               fin   = 1'b1;
               fcode = XC_SEG;
            end else if (mem_req_ready) begin
               nxt = S_SEG_WAIT;
            end
         end
         S_SEG_WAIT: begin
            if (mem_rsp_valid) begin
               if (seg_inv) begin
                  fin   = 1'b1;
                  fcode = XC_SEG;
               end else if (len_over) begin
                  fin   = 1'b1;
                  fcode = XC_PAGE;
               end else begin
                  nxt = S_PG_REQ;
               end
            end
         end
         S_PG_REQ:   if (mem_req_ready) nxt = S_PG_WAIT;
         S_PG_WAIT: begin
            if (mem_rsp_valid) begin
               fin = 1'b1;
               if (pg_inv)      fcode = XC_PAGE;
               else if (pg_rsv) fcode = XC_SPEC;
               else             fcode = XC_NONE;
            end
         end
         default:    nxt = S_IDLE;
      endcase
      if (fin) nxt = S_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         va_q     <= '0;
         str_q    <= '0;
         mode_q   <= 1'b0;
         pto_q    <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         pa       <= '0;
         exc_code <= XC_NONE;
         tea      <= '0;
      end else begin
         st   <= nxt;
         done <= fin;
         if (st == S_IDLE && start) begin
            va_q   <= va;
            str_q  <= str;
            mode_q <= mode_in;
            busy   <= 1'b1;
         end
         if (st == S_SEG_WAIT && mem_rsp_valid) pto_q <= pto_w;
         if (fin) begin
            busy     <= 1'b0;
            exc_code <= fcode;
            if (fcode == XC_NONE) begin
               pa <= {block, va_q[OFF_W-1:0]};
            end else begin
               pa  <= '0;
               tea <= va_q;
            end
         end
      end
   end

endmodule

// File: rtl/xw_checker.sv
module xw_checker
   import xw_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int VA_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] pa,
   input logic [7:0]        exc_code,
   input logic [VA_W-1:0]   tea,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_req_half
);

   a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_half));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

   a_r11_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   a_r11_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   a_r11_results_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(pa) && $stable(exc_code));

   a_r9_tea_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(tea));

   a_r8_pa_zero_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
      done && exc_code != XC_NONE |-> pa == '0);

   a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      exc_code == XC_NONE || exc_code == XC_SPEC || exc_code == XC_SEG || exc_code == XC_PAGE);

   a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_half |-> mem_req_addr[1:0] == 2'b00);

   a_r5_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_half |-> mem_req_addr[0] == 1'b0);

endmodule

bind xlat_walker xw_checker #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_xw_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .pa(pa), .exc_code(exc_code), .tea(tea),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .mem_req_half(mem_req_half)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;

   logic        clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode32 = 1'b0;
   logic [31:0] va = '0;
   logic [31:0] str = '0;
   logic        busy, done;
   logic [23:0] pa;
   logic [7:0]  exc_code;
   logic [31:0] tea;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [23:0] mem_req_addr;
   logic        mem_req_half;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   xlat_walker i_xlat_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .va(va), .mode32(mode32), .str(str),
      .busy(busy), .done(done), .pa(pa), .exc_code(exc_code), .tea(tea),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_half(mem_req_half),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   int vectors = 0;
   int miscompares = 0;

   logic [7:0]  mem [int unsigned];
   logic [24:0] exp_q [$];
   int lat_cfg = 1, stall_cfg = 0, lat_cnt = 0, stall_left = 0, rd_cnt = 0;

   logic [23:0] pend_pa, cur_pa = '0;
   logic [7:0]  pend_code, cur_code = '0;
   logic [31:0] pend_tea, cur_tea = '0;
   int          pend_reads = 0;
   bit          have_res = 1'b0;
   bit          done_seen = 1'b0;
   string       cur_req = "R8";

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
      vectors++;
      if (act !== expv) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, expv, $time);
      end
   endtask

   function automatic logic [7:0] rd8(int unsigned a);
      if (mem.exists(a)) return mem[a];
      return 8'h00;
   endfunction
   function automatic logic [15:0] rd16(int unsigned a);
      return {rd8(a), rd8(a + 1)};
   endfunction
   function automatic logic [31:0] rd32(int unsigned a);
      return {rd8(a), rd8(a + 1), rd8(a + 2), rd8(a + 3)};
   endfunction
   task automatic put16(int unsigned a, logic [15:0] h);
      mem[a] = h[15:8]; mem[a + 1] = h[7:0];
   endtask
   task automatic put32(int unsigned a, logic [31:0] w);
      mem[a] = w[31:24]; mem[a + 1] = w[23:16]; mem[a + 2] = w[15:8]; mem[a + 3] = w[7:0];
   endtask

   // behavioural reference walk
   task automatic predict(logic [31:0] v, logic [31:0] s, bit m);
      int unsigned six, lim, sa, pix, ptl, pto, paddr;
      logic [31:0] w;
      logic [15:0] h;
      pend_reads = 0;
      pend_pa    = '0;
      pend_tea   = v;
      six = m ? (v >> 20) : ((v >> 20) & 15);
      if (m) begin
         lim = (s >> 24) * 16 + 15;
         if (six > lim) begin pend_code = 8'd16; return; end
      end
      sa = ((s & 32'h00FF_FFC0) + 4 * six) & 32'h00FF_FFFF;
      exp_q.push_back({1'b0, sa[23:0]});
      pend_reads = 1;
      w = rd32(sa);
      if (w[0]) begin pend_code = 8'd16; return; end
      ptl = w >> 24;
      pix = (v >> 12) & 255;
      if (pix > ptl) begin pend_code = 8'd17; return; end
      pto   = w & 32'h00FF_FFFE;
      paddr = (pto + 2 * pix) & 32'h00FF_FFFF;
      exp_q.push_back({1'b1, paddr[23:0]});
      pend_reads = 2;
      h = rd16(paddr);
      if (h[3])                begin pend_code = 8'd17; return; end
      if (h[2:0] != 3'b000)    begin pend_code = 8'd6;  return; end
      pend_code = 8'd0;
      pend_pa   = {h[15:4], v[11:0]};
      pend_tea  = cur_tea;
   endtask

   // memory model: decides at each falling edge
   initial begin
      logic [24:0] e;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_req_ready = 1'b0;
         if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) mem_rsp_valid = 1'b1;
         end else if (rst_n && mem_req_valid) begin
            if (stall_left > 0) begin
               stall_left--;
            end else begin
               mem_req_ready = 1'b1;
               stall_left    = stall_cfg;
               rd_cnt++;
               if (exp_q.size() == 0) begin
                  check(mem_req_half ? "R5" : "R2", "unexpected read", {7'b0, mem_req_half, mem_req_addr}, 32'hFFFF_FFFF);
               end else begin
                  e = exp_q.pop_front();
                  check(e[24] ? "R5" : "R2", "request", {7'b0, mem_req_half, mem_req_addr}, {7'b0, e});
               end
               mem_rsp_data = mem_req_half ? {16'h0, rd16(mem_req_addr)} : rd32(mem_req_addr);
               lat_cnt      = lat_cfg;
            end
         end
      end
   end

   // per-clock comparison against the reference result
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done) begin
               check(cur_req, "exc_code", {24'b0, exc_code}, {24'b0, pend_code});
               check("R8", "pa", {8'b0, pa}, {8'b0, pend_pa});
               check("R9", "tea", tea, pend_tea);
               check(cur_req, "read count", rd_cnt, pend_reads);
               check("R11", "busy at done", {31'b0, busy}, 32'd0);
               cur_pa = pend_pa; cur_code = pend_code; cur_tea = pend_tea;
               have_res  = 1'b1;
               done_seen = 1'b1;
            end else if (!busy && have_res) begin
               check("R11", "held pa", {8'b0, pa}, {8'b0, cur_pa});
               check("R11", "held code", {24'b0, exc_code}, {24'b0, cur_code});
               check("R11", "held tea", tea, cur_tea);
            end
         end
      end
   end

   task automatic run(string req, logic [31:0] v, logic [31:0] s, bit m, int lat, int stall, bit poke);
      while (busy) @(negedge clk);
      lat_cfg = lat; stall_cfg = stall; stall_left = stall;
      predict(v, s, m);
      rd_cnt = 0; cur_req = req; done_seen = 1'b0;
      va = v; str = s; mode32 = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0; va = 32'hDEAD_BEEF; str = 32'hFFFF_FFFF; mode32 = ~m;
      if (poke) begin
         // R11: a second start while busy must be ignored
         check("R11", "busy after start", {31'b0, busy}, 32'd1);
         start = 1'b1; va = 32'h0010_0000;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      if (poke) begin
         repeat (3) @(negedge clk);
         check("R11", "no second walk", {31'b0, busy}, 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      // segment table at 0x1000
      put32(32'h1004, 32'h0F00_2000);   // seg 1: length 15, table 0x2000
      put32(32'h1008, 32'h0000_3001);   // seg 2: unavailable
      put32(32'h100C, 32'h0000_2400);   // seg 3: length 0
      put32(32'h1014, 32'hFF00_2802);   // seg 5: length 255, halfword-aligned table
      put16(32'h2000, 16'hABC0);        // pix 0 ok
      put16(32'h2006, 16'h1238);        // pix 3 unavailable
      put16(32'h2008, 16'h000F);        // pix 4 unavailable plus reserved bits
      put16(32'h200E, 16'h4565);        // pix 7 reserved bits
      put16(32'h201E, 16'h7770);        // pix 15 ok (last allowed)
      put16(32'h2400, 16'h0010);
      put16(32'h2A00, 16'hFFF0);        // seg 5 pix 255
      put16(32'h2902, 16'h5550);        // seg 5 pix 128
      // wide-mode table at 0x3000
      put32(32'h303C, 32'h0000_2C00);   // seg 15
      put32(32'h3040, 32'h0000_0001);   // seg 16: unavailable
      put16(32'h2C00, 16'h9990);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "busy", {31'b0, busy}, 32'd0);
      check("R1", "done", {31'b0, done}, 32'd0);
      check("R1", "pa", {8'b0, pa}, 32'd0);
      check("R1", "exc_code", {24'b0, exc_code}, 32'd0);
      check("R1", "tea", tea, 32'd0);
      check("R1", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);

      run("R8",  32'h0010_0123, 32'h0000_1000, 1'b0, 1, 0, 1'b0);
      run("R2",  32'hFF10_00AB, 32'h0000_103A, 1'b0, 3, 2, 1'b0);
      run("R3",  32'h0020_0555, 32'h0000_1000, 1'b0, 2, 0, 1'b0);
      run("R6",  32'h0010_3777, 32'h0000_1000, 1'b0, 1, 1, 1'b0);
      run("R8",  32'h0010_F001, 32'h0000_1000, 1'b0, 4, 0, 1'b0);
      run("R4",  32'h0011_0002, 32'h0000_1000, 1'b0, 1, 0, 1'b0);
      run("R7",  32'h0010_7FFF, 32'h0000_1000, 1'b0, 2, 3, 1'b0);
      run("R6",  32'h0010_4000, 32'h0000_1000, 1'b0, 1, 0, 1'b0);
      run("R4",  32'h0030_0ABC, 32'h0000_1000, 1'b0, 1, 0, 1'b0);
      run("R4",  32'h0030_1ABC, 32'h0000_1000, 1'b0, 1, 0, 1'b0);
      run("R5",  32'h005F_F321, 32'h0000_1000, 1'b0, 2, 1, 1'b0);
      run("R5",  32'h0058_0FED, 32'h0000_1000, 1'b0, 1, 0, 1'b0);
      run("R10", 32'h0100_0123, 32'h0000_303F, 1'b1, 1, 0, 1'b0);
      run("R10", 32'h00F0_0ABC, 32'h0000_3000, 1'b1, 2, 1, 1'b0);
      run("R10", 32'h0100_0456, 32'h0100_3000, 1'b1, 1, 0, 1'b0);
      run("R11", 32'h0010_0042, 32'h0000_1000, 1'b0, 3, 1, 1'b1);
      run("R11", 32'h0020_0000, 32'h0000_1000, 1'b0, 3, 0, 1'b1);

      repeat (4) @(negedge clk);
      check("R4", "leftover expected reads", exp_q.size(), 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule